// File: doc/BRIEF.md
# Vertical Gate-Drive Pulse Generator

This block produces the row-scanning control pulses for an active-matrix panel. It runs on a fast system clock. It receives a line strobe once per horizontal period and a frame strobe once per picture. Each accepted line strobe toggles the row clock once, so the rising and falling edges both advance the panel's row register. Around that transition the block places three auxiliary pulses: a precharge pulse that ends a fixed time before the transition, a clear pulse that ends on the transition itself, and a gate-enable window that opens a fixed time after it.

The block asserts a row start pulse around the transition of the first line after a frame strobe. A line counter wraps after a full frame, so without a new frame strobe the start pulse comes back once every frame. The scan-direction level is registered and passed through to the panel. Every delay and width is a parameter counted in system clock cycles. The defaults assume a 20 MHz clock, where one cycle is 50 ns.

Top module: `vgd_gate_pulser`

## Requirements
- R1: After reset every output is low. All outputs stay low, and line strobes are ignored, until the first frame strobe has been sampled. A line strobe in the same cycle as that first frame strobe is also ignored.
- R2: Each accepted line strobe toggles `row_clk` exactly once, VCK_OFS+1 clock edges after the edge that samples the strobe. Successive lines alternate the edge: rising for the first line after arming, then falling, and so on.
- R3: `gate_en` rises ENB_DLY cycles after each `row_clk` transition and stays high for ENB_W cycles. The defaults are 8 and 70, which is 400 ns and 3.5 us at 50 ns per cycle.
- R4: `prechg` is high for PCG_W cycles and falls PCG_LEAD cycles before each `row_clk` transition. The defaults are 24 and 14, which is 1.2 us and 700 ns.
- R5: `unif_clr` is high for CLR_W cycles. It falls in the same cycle as the `row_clk` transition. The default is 62 cycles, which is 3.1 us.
- R6: `row_start` rises VST_SU cycles before, and falls VST_HD cycles after, the `row_clk` transition of the first line after a frame strobe. It stays low on every other line.
- R7: After LINES lines with no new frame strobe, the line count wraps to zero, and the next line carries `row_start` again.
- R8: A frame strobe in the middle of a frame restarts the count, so the next line carries `row_start`.
- R9: Once armed, `scan_down` equals `dir_down` one cycle later. A value of 1 selects downward scan and 0 selects upward scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame start strobe |
| line_stb | input | 1 | One-cycle line start strobe |
| dir_down | input | 1 | Scan direction request (1 down, 0 up) |
| row_clk | output | 1 | Row shift clock, toggles once per line |
| row_start | output | 1 | Row start pulse on the first line of a frame |
| gate_en | output | 1 | Gate enable window after each row clock edge |
| prechg | output | 1 | Precharge pulse before each row clock edge |
| unif_clr | output | 1 | Uniformity clear pulse ending on the row clock edge |
| scan_down | output | 1 | Registered scan direction level |

## Verification
A single line timer drives all pulses. A wrong timer value therefore moves every pulse of that line by the same amount, and that offset can be seen within one line as a shift between the strobe and the `row_clk` transition. A fault in one window bound instead shifts only that pulse relative to `row_clk`. The bench measures each edge to the exact cycle and also checks it against the allowed time window. A wrong line count or first-line flag appears only at the start pulse. It shows on the first line, on the line after a wrap, or on the line after a frame restart, so the bench runs more than one frame.

// File: rtl/vgd_pkg.sv
// Shared definitions for the vertical gate-drive pulse generator.
// Assumes: window indices are used to pick bounds in a generate loop.
package vgd_pkg;
    // Index of each pulse window built from the line timer.
    typedef enum int {
        WIN_ENB = 0,
        WIN_PCG = 1,
        WIN_CLR = 2,
        WIN_VST = 3
    } win_e;

    localparam int NUM_WIN = 4;
endpackage

// File: rtl/vgd_line_timer.sv
// Line timer: restarts at zero on each accepted line strobe and counts up
// until it reaches END, where it parks. END is the idle value.
// Assumes: END fits in TW bits.
module vgd_line_timer #(
    parameter int END = 142,
    parameter int TW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [TW-1:0] t
);
    localparam logic [TW-1:0] END_T = TW'(END);

    // Restart on start, count while below END, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          t <= END_T;
        else if (start)      t <= '0;
        else if (t != END_T) t <= t + 1'b1;
    end
endmodule

// File: rtl/vgd_pulse_win.sv
// Registered window pulse: high one cycle after the timer enters [LO, HI),
// low one cycle after it leaves. Gated by en.
// Assumes: LO < HI and both fit in TW bits.
module vgd_pulse_win #(
    parameter int TW = 8,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] t,
    output logic          q
);
    localparam logic [TW-1:0] LO_T = TW'(LO);
    localparam logic [TW-1:0] HI_T = TW'(HI);

    // Register window membership so every pulse shares one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= en && (t >= LO_T) && (t < HI_T);
    end
endmodule

// File: rtl/vgd_frame_ctl.sv
// Frame control: arms on the first frame strobe, qualifies line strobes,
// counts lines per frame and latches whether the current line is the first
// one. Also registers the scan direction.
// Assumes: LINES >= 2; frame and line strobes are one cycle wide.
module vgd_frame_ctl #(
    parameter int LINES = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic line_stb,
    input  logic edge_tick,
    input  logic dir_down,
    output logic armed,
    output logic line_go,
    output logic first,
    output logic scan_down
);
    localparam int LW = (LINES > 2) ? $clog2(LINES) : 1;
    localparam logic [LW-1:0] LAST = LW'(LINES - 1);

    logic [LW-1:0] lidx;

    assign line_go = line_stb & armed;

    // Arm once the first frame strobe is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= armed | frame_stb;
    end

    // Line index: cleared by a frame strobe, advanced on each row clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         lidx <= '0;
        else if (frame_stb) lidx <= '0;
        else if (edge_tick) lidx <= (lidx == LAST) ? '0 : lidx + 1'b1;
    end

    // Latch the first-line flag at the start of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)       first <= 1'b0;
        else if (line_go) first <= (lidx == '0);
    end

    // Pass the direction through, held low until armed.
    always_ff @(posedge clk) begin
        if (!rst_n) scan_down <= 1'b0;
        else        scan_down <= armed & dir_down;
    end
endmodule

// File: rtl/vgd_gate_pulser.sv
// Vertical gate-drive pulse generator. Each accepted line strobe starts a
// line timer. The row clock toggles at VCK_OFS. Precharge, clear, enable and
// start windows are fixed offsets around that point.
// Assumes: VCK_OFS >= max(CLR_W, PCG_LEAD+PCG_W, VST_SU); VST_HD < ENB_DLY+ENB_W;
// line strobes arrive more than LINE_END cycles apart.
module vgd_gate_pulser #(
    parameter int LINES    = 480,
    parameter int VCK_OFS  = 64,
    parameter int ENB_DLY  = 8,
    parameter int ENB_W    = 70,
    parameter int PCG_LEAD = 14,
    parameter int PCG_W    = 24,
    parameter int CLR_W    = 62,
    parameter int VST_SU   = 4,
    parameter int VST_HD   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic line_stb,
    input  logic dir_down,
    output logic row_clk,
    output logic row_start,
    output logic gate_en,
    output logic prechg,
    output logic unif_clr,
    output logic scan_down
);
    import vgd_pkg::*;

    localparam int LINE_END = VCK_OFS + ENB_DLY + ENB_W;
    localparam int TW = $clog2(LINE_END + 1);
    localparam logic [TW-1:0] EDGE_T = TW'(VCK_OFS);

    localparam int WLO [NUM_WIN] = '{VCK_OFS + ENB_DLY, VCK_OFS - PCG_LEAD - PCG_W,
                                     VCK_OFS - CLR_W,   VCK_OFS - VST_SU};
    localparam int WHI [NUM_WIN] = '{LINE_END,          VCK_OFS - PCG_LEAD,
                                     VCK_OFS,           VCK_OFS + VST_HD};

    logic [TW-1:0]      t;
    logic               armed, line_go, first, edge_tick;
    logic [NUM_WIN-1:0] win_en, win_q;

    assign edge_tick = (t == EDGE_T);
    assign win_en    = {first, 3'b111};

    vgd_frame_ctl #(.LINES(LINES)) u_frame (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
        .edge_tick(edge_tick), .dir_down(dir_down), .armed(armed),
        .line_go(line_go), .first(first), .scan_down(scan_down)
    );

    vgd_line_timer #(.END(LINE_END), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(line_go), .t(t)
    );

    // One registered window per auxiliary pulse.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        vgd_pulse_win #(.TW(TW), .LO(WLO[g]), .HI(WHI[g])) u_win (
            .clk(clk), .rst_n(rst_n), .en(win_en[g]), .t(t), .q(win_q[g])
        );
    end

    assign gate_en   = win_q[WIN_ENB];
    assign prechg    = win_q[WIN_PCG];
    assign unif_clr  = win_q[WIN_CLR];
    assign row_start = win_q[WIN_VST];

    // Row clock flips once per line, with the same latency as the windows.
    always_ff @(posedge clk) begin
        if (!rst_n) row_clk <= 1'b0;
        else        row_clk <= row_clk ^ edge_tick;
    end
endmodule

// File: rtl/vgd_gate_pulser_chk.sv
// Checker for vgd_gate_pulser: relates the pulses to the row clock edges and
// to the arming state over time. Bound to every instance of the top.
module vgd_gate_pulser_chk (
    input logic clk,
    input logic rst_n,
    input logic armed,
    input logic dir_down,
    input logic row_clk,
    input logic row_start,
    input logic gate_en,
    input logic prechg,
    input logic unif_clr,
    input logic scan_down
);
    // R1
    quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !(row_clk || row_start || gate_en || prechg || unif_clr || scan_down));

    // R5
    clr_ends_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clk != $past(row_clk)) |-> $fell(unif_clr));

    // R4
    edge_clear_of_pcg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clk != $past(row_clk)) |-> (!prechg && !gate_en));

    // R3
    enb_rise_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> (!unif_clr && !prechg));

    // R6
    vst_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |-> (!prechg && !gate_en));

    // R9
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> (scan_down == $past(dir_down)));
endmodule

bind vgd_gate_pulser vgd_gate_pulser_chk u_chk (
    .clk(clk), .rst_n(rst_n), .armed(armed), .dir_down(dir_down),
    .row_clk(row_clk), .row_start(row_start), .gate_en(gate_en),
    .prechg(prechg), .unif_clr(unif_clr), .scan_down(scan_down)
);

// File: tb/sim_vgd_gate_pulser.sv
`timescale 1ns/1ps
module sim_vgd_gate_pulser;
    localparam int CLK_PERIOD = 50;
    localparam int LINES = 6;
    localparam int LINE_GAP = 200;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0, line_stb = 1'b0, dir_down = 1'b0;
    logic row_clk, row_start, gate_en, prechg, unif_clr, scan_down;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int t_vck, t_enb_r, t_enb_f, t_pcg_r, t_pcg_f, t_clr_r, t_clr_f, t_vst_r, t_vst_f;
    int n_vck = 0, n_vst = 0;
    logic p_vck = 0, p_enb = 0, p_pcg = 0, p_clr = 0, p_vst = 0;

    vgd_gate_pulser #(.LINES(LINES)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
        .dir_down(dir_down), .row_clk(row_clk), .row_start(row_start),
        .gate_en(gate_en), .prechg(prechg), .unif_clr(unif_clr), .scan_down(scan_down)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (row_clk != p_vck) begin t_vck = cyc; n_vck++; end
        if (gate_en && !p_enb) t_enb_r = cyc;
        if (!gate_en && p_enb) t_enb_f = cyc;
        if (prechg && !p_pcg) t_pcg_r = cyc;
        if (!prechg && p_pcg) t_pcg_f = cyc;
        if (unif_clr && !p_clr) t_clr_r = cyc;
        if (!unif_clr && p_clr) t_clr_f = cyc;
        if (row_start && !p_vst) begin t_vst_r = cyc; n_vst++; end
        if (!row_start && p_vst) t_vst_f = cyc;
        p_vck = row_clk; p_enb = gate_en; p_pcg = prechg; p_clr = unif_clr; p_vst = row_start;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ns(input string req, input int cycles, input int lo, input int hi);
        n_chk++;
        if (cycles * CLK_PERIOD < lo || cycles * CLK_PERIOD > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d ns expected %0d..%0d ns", req, cycles * CLK_PERIOD, lo, hi);
        end
    endtask

    task automatic report;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Issue one line strobe and let the line run out; returns the strobe cycle.
    task automatic run_line(output int sc);
        @(negedge clk); line_stb = 1'b1; sc = cyc;
        @(negedge clk); line_stb = 1'b0;
        repeat (LINE_GAP - 1) @(negedge clk);
    endtask

    task automatic pulse_frame;
        @(negedge clk); frame_stb = 1'b1;
        @(negedge clk); frame_stb = 1'b0;
    endtask

    // Timing of one line against its own row clock transition.
    task automatic check_line_timing(input int sc);
        chk("R2 strobe to row_clk", t_vck - sc, 66);
        chk("R3 enb delay", t_enb_r - t_vck, 8);
        chk("R3 enb width", t_enb_f - t_enb_r, 70);
        chk_ns("R3 enb delay ns", t_enb_r - t_vck, 350, 450);
        chk_ns("R3 enb width ns", t_enb_f - t_enb_r, 3450, 3550);
        chk("R4 pcg lead", t_vck - t_pcg_f, 14);
        chk("R4 pcg width", t_pcg_f - t_pcg_r, 24);
        chk_ns("R4 pcg lead ns", t_vck - t_pcg_f, 650, 750);
        chk_ns("R4 pcg width ns", t_pcg_f - t_pcg_r, 1150, 1250);
        chk("R5 clr fall on edge", t_clr_f, t_vck);
        chk("R5 clr width", t_clr_f - t_clr_r, 62);
        chk_ns("R5 clr width ns", t_clr_f - t_clr_r, 3000, 3200);
    endtask

    task automatic test_reset;
        int sc;
        chk("R1 reset row_clk", row_clk, 0);
        chk("R1 reset outputs", {row_start, gate_en, prechg, unif_clr, scan_down}, 0);
        dir_down = 1'b1;
        run_line(sc);
        run_line(sc);
        chk("R1 no row_clk edge before arming", n_vck, 0);
        chk("R1 no pulses before arming", {row_clk, row_start, gate_en, prechg, unif_clr, scan_down}, 0);
        // Line strobe in the same cycle as the first frame strobe is ignored.
        @(negedge clk); frame_stb = 1'b1; line_stb = 1'b1;
        @(negedge clk); frame_stb = 1'b0; line_stb = 1'b0;
        repeat (LINE_GAP) @(negedge clk);
        chk("R1 coincident strobe ignored", n_vck, 0);
        chk("R9 scan_down after arming", scan_down, 1);
    endtask

    task automatic test_first_line;
        int sc;
        run_line(sc);
        chk("R2 first edge rises", row_clk, 1);
        chk("R2 one edge", n_vck, 1);
        check_line_timing(sc);
        chk("R6 vst setup", t_vck - t_vst_r, 4);
        chk("R6 vst hold", t_vst_f - t_vck, 4);
        chk("R6 one vst", n_vst, 1);
    endtask

    task automatic test_rest_of_frame;
        int sc;
        for (int i = 2; i <= LINES; i++) begin
            run_line(sc);
            chk("R2 row_clk alternates", row_clk, i % 2);
            if (i == 2 || i == LINES) check_line_timing(sc);
        end
        chk("R2 edge count", n_vck, LINES);
        chk("R6 no vst on later lines", n_vst, 1);
    endtask

    task automatic test_wrap;
        int sc;
        run_line(sc);
        chk("R7 vst after wrap", n_vst, 2);
        chk("R7 vst setup", t_vck - t_vst_r, 4);
        run_line(sc);
        chk("R7 no vst on next line", n_vst, 2);
    endtask

    task automatic test_restart;
        int sc;
        pulse_frame();
        run_line(sc);
        chk("R8 vst after restart", n_vst, 3);
        chk("R8 vst hold", t_vst_f - t_vck, 4);
        check_line_timing(sc);
    endtask

    task automatic test_dir;
        @(negedge clk); dir_down = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 scan_down up", scan_down, 0);
        @(negedge clk); dir_down = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 scan_down down", scan_down, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_first_line();
        test_rest_of_frame();
        test_wrap();
        test_restart();
        test_dir();
        report();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        report();
    end
endmodule